// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Cause and Mask

This block holds two independent 32-bit down-counters that advance on a shared tick strobe. A shared control word gives each counter a run enable and a choice between periodic and one-shot operation. Each counter has its own reload register and a live count register. When a counter expires, it sets a sticky cause bit. That cause bit, gated by a matching mask bit, drives a per-timer interrupt line.

Software reaches every register through a simple synchronous port with a write strobe, a read strobe, a byte address and a data word. There are two common ways to use the block. A free-running periodic counter can serve as a time base: software reads the count and inverts it to get elapsed ticks. A one-shot counter can serve as an event timer: software acknowledges the cause bit, then arms the counter by writing a value to it.

Top module: `dual_timer`

## Requirements
- R1: After a synchronous reset, every mapped register reads zero and both interrupt lines are low.
- R2: The control word sits at 0x000. Timer i is enabled by bit 2i and switched to periodic mode by bit 2i+1. Timer i's reload register is at 0x010+8i and its count register at 0x014+8i. All of them read back what was last written, apart from count changes made by the counter itself.
- R3: While a timer is enabled and the tick input is high, its count falls by one per clock. When tick is low or the timer is disabled, the count holds.
- R4: A periodic timer at count zero responds to a tick by loading its reload value and signalling expiry. This gives one expiry every reload+1 ticks.
- R5: A one-shot timer at count zero responds to a tick by signalling expiry once and staying at zero. Its enable bit stays set. It does not expire again until its count register is written.
- R6: A write to a count register loads the counter at that clock edge and arms it for one-shot use. The write overrides any decrement, reload or expiry in that same cycle.
- R7: Timer i's expiry sets bit i+1 of the cause register at 0x110. The bit stays set until software clears it. All other cause bits read zero.
- R8: In a write to the cause register, a 0 clears the corresponding cause bit and a 1 leaves it unchanged. If an expiry lands in the same cycle as a clearing write, the bit stays set.
- R9: The mask register at 0x114 uses the same bit positions as the cause register. An interrupt line is high in the clock after the one in which both its cause bit and its mask bit are set. A timer whose mask bit is clear never raises its line.
- R10: Read data is registered. It updates one clock after a read strobe and holds otherwise. Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe shared by both timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | N_TMR | Interrupt line per timer |

## Verification
The hardest situations to reach from the ports are those where two events land on the same clock edge: an expiry coinciding with a clearing write to the cause register, and a count write coinciding with a tick at zero. Directed cases make these alignments easy. A periodic timer with reload zero expires on every tick, so any clearing write issued while ticking collides with an expiry. A count of zero written just before a ticking write lines up the override case. A long random phase then uses small count and reload values, so expiries arrive often and overlap register writes at varied phases.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned OFS_CTRL     = 32'h000;
  localparam int unsigned OFS_TMR_BASE = 32'h010;
  localparam int unsigned TMR_STRIDE   = 8;
  localparam int unsigned OFS_RLD      = 0;
  localparam int unsigned OFS_VAL      = 4;
  localparam int unsigned OFS_CAUSE    = 32'h110;
  localparam int unsigned OFS_MASK     = 32'h114;
  localparam int unsigned CAUSE_LSB    = 1;
  localparam int unsigned IDX_W        = 5;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_RLD,
    RK_VAL,
    RK_CAUSE,
    RK_MASK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      sel.kind = RK_CTRL;
    end else if (addr == ADDR_W'(OFS_CAUSE)) begin
      sel.kind = RK_CAUSE;
    end else if (addr == ADDR_W'(OFS_MASK)) begin
      sel.kind = RK_MASK;
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (addr == ADDR_W'(OFS_TMR_BASE + i * TMR_STRIDE + OFS_RLD)) begin
          sel.kind = RK_RLD;
          sel.idx  = IDX_W'(i);
        end
        if (addr == ADDR_W'(OFS_TMR_BASE + i * TMR_STRIDE + OFS_VAL)) begin
          sel.kind = RK_VAL;
          sel.idx  = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              auto_rld,
  input  logic              rld_wr,
  input  logic              val_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] rld_q,
  output logic              expire
);
  logic armed;
  logic at_zero;
  logic step;

  assign at_zero = (count == '0);
  assign step    = tick && en;
  // a software load wins over anything the counter would do this cycle
  assign expire  = step && at_zero && (auto_rld || armed) && !val_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      rld_q <= '0;
      armed <= 1'b0;
    end else begin
      if (rld_wr) begin
        rld_q <= wdata;
      end
      if (val_wr) begin
        count <= wdata;
        armed <= 1'b1;
      end else begin
        if (expire) begin
          armed <= 1'b0;
        end
        if (step) begin
          if (!at_zero) begin
            count <= count - 1'b1;
          end else if (auto_rld) begin
            count <= rld_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cause_wr,
  input  logic             mask_wr,
  input  logic [N_TMR-1:0] wr_bits,
  input  logic [N_TMR-1:0] expire,
  output logic [N_TMR-1:0] cause_bits,
  output logic [N_TMR-1:0] mask_bits,
  output logic [N_TMR-1:0] irq
);
  logic [N_TMR-1:0] keep;

  // write-zero-to-clear; bits written as one are kept
  assign keep = cause_wr ? wr_bits : {N_TMR{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_bits <= '0;
      mask_bits  <= '0;
      irq        <= '0;
    end else begin
      cause_bits <= (cause_bits & keep) | expire;
      if (mask_wr) begin
        mask_bits <= wr_bits;
      end
      irq <= cause_bits & mask_bits;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_TMR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq
);
  localparam int CTRL_W = 2 * N_TMR;

  reg_sel_t                     sel;
  logic [CTRL_W-1:0]            ctrl_q;
  logic [N_TMR-1:0]             val_wr;
  logic [N_TMR-1:0]             rld_wr;
  logic [N_TMR-1:0]             expire;
  logic [N_TMR-1:0]             cause_bits;
  logic [N_TMR-1:0]             mask_bits;
  logic [N_TMR-1:0][DATA_W-1:0] cnt_all;
  logic [N_TMR-1:0][DATA_W-1:0] rld_all;
  logic                         cause_wr;
  logic                         mask_wr;
  logic [DATA_W-1:0]            rd_mux;

  dtmr_decode #(.ADDR_W(ADDR_W), .N_TMR(N_TMR)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign cause_wr = bus_wr && (sel.kind == RK_CAUSE);
  assign mask_wr  = bus_wr && (sel.kind == RK_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (bus_wr && (sel.kind == RK_CTRL)) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign rld_wr[g] = bus_wr && (sel.kind == RK_RLD) && (sel.idx == IDX_W'(g));
    assign val_wr[g] = bus_wr && (sel.kind == RK_VAL) && (sel.idx == IDX_W'(g));

    dtmr_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .en       (ctrl_q[2*g]),
      .auto_rld (ctrl_q[2*g+1]),
      .rld_wr   (rld_wr[g]),
      .val_wr   (val_wr[g]),
      .wdata    (bus_wdata),
      .count    (cnt_all[g]),
      .rld_q    (rld_all[g]),
      .expire   (expire[g])
    );
  end

  dtmr_irq #(.N_TMR(N_TMR)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .cause_wr   (cause_wr),
    .mask_wr    (mask_wr),
    .wr_bits    (bus_wdata[CAUSE_LSB +: N_TMR]),
    .expire     (expire),
    .cause_bits (cause_bits),
    .mask_bits  (mask_bits),
    .irq        (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      RK_CTRL:  rd_mux = DATA_W'(ctrl_q);
      RK_CAUSE: rd_mux[CAUSE_LSB +: N_TMR] = cause_bits;
      RK_MASK:  rd_mux[CAUSE_LSB +: N_TMR] = mask_bits;
      RK_RLD: begin
        for (int i = 0; i < N_TMR; i++) begin
          if (sel.idx == IDX_W'(i)) rd_mux = rld_all[i];
        end
      end
      RK_VAL: begin
        for (int i = 0; i < N_TMR; i++) begin
          if (sel.idx == IDX_W'(i)) rd_mux = cnt_all[i];
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int DATA_W = 32,
  parameter int N_TMR  = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tick,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [2*N_TMR-1:0]           ctrl_q,
  input logic [N_TMR-1:0]             val_wr,
  input logic [N_TMR-1:0][DATA_W-1:0] cnt_all,
  input logic [N_TMR-1:0][DATA_W-1:0] rld_all,
  input logic [N_TMR-1:0]             expire,
  input logic [N_TMR-1:0]             cause_bits,
  input logic [N_TMR-1:0]             mask_bits,
  input logic [N_TMR-1:0]             irq
);
  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
      (tick && ctrl_q[2*g] && cnt_all[g] != '0 && !val_wr[g])
        |=> cnt_all[g] == $past(cnt_all[g]) - 1'b1);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!(tick && ctrl_q[2*g]) && !val_wr[g]) |=> $stable(cnt_all[g]));

    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
      (tick && ctrl_q[2*g] && ctrl_q[2*g+1] && cnt_all[g] == '0 && !val_wr[g])
        |=> cnt_all[g] == $past(rld_all[g]));

    assert_oneshot_rest_R5: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_q[2*g+1] && cnt_all[g] == '0 && !val_wr[g]) |=> cnt_all[g] == '0);

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
      val_wr[g] |=> cnt_all[g] == $past(bus_wdata));

    assert_cause_set_R7: assert property (@(posedge clk) disable iff (rst)
      expire[g] |=> cause_bits[g]);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> irq[g] == ($past(cause_bits[g]) && $past(mask_bits[g])));
  end
endmodule

bind dual_timer dual_timer_chk #(.DATA_W(DATA_W), .N_TMR(N_TMR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .bus_wdata  (bus_wdata),
  .ctrl_q     (ctrl_q),
  .val_wr     (val_wr),
  .cnt_all    (cnt_all),
  .rld_all    (rld_all),
  .expire     (expire),
  .cause_bits (cause_bits),
  .mask_bits  (mask_bits),
  .irq        (irq)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_RLD0  = 12'h010;
  localparam logic [11:0] A_VAL0  = 12'h014;
  localparam logic [11:0] A_RLD1  = 12'h018;
  localparam logic [11:0] A_VAL1  = 12'h01C;
  localparam logic [11:0] A_CAUSE = 12'h110;
  localparam logic [11:0] A_MASK  = 12'h114;
  localparam logic [11:0] A_HOLE  = 12'h020;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R1";

  // reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_rld [2];
  logic        m_arm [2];
  logic [3:0]  m_ctrl;
  logic [1:0]  m_cause, m_mask, m_irq;
  logic [31:0] m_rdata;

  always #5 clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] read_model(input logic [11:0] a);
    case (a)
      A_CTRL:  return {28'd0, m_ctrl};
      A_RLD0:  return m_rld[0];
      A_VAL0:  return m_cnt[0];
      A_RLD1:  return m_rld[1];
      A_VAL1:  return m_cnt[1];
      A_CAUSE: return {29'd0, m_cause, 1'b0};
      A_MASK:  return {29'd0, m_mask, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      A_CTRL, A_RLD0, A_RLD1: return "R2";
      A_VAL0, A_VAL1:         return "R3";
      A_CAUSE:                return "R7";
      A_MASK:                 return "R9";
      default:                return "R10";
    endcase
  endfunction

  function automatic logic [11:0] addr_pick(input int unsigned k);
    case (k % 8)
      0: return A_CTRL;  1: return A_RLD0; 2: return A_VAL0; 3: return A_RLD1;
      4: return A_VAL1;  5: return A_CAUSE; 6: return A_MASK; default: return A_HOLE;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = '0; m_rld[i] = '0; m_arm[i] = 1'b0;
    end
    m_ctrl = '0; m_cause = '0; m_mask = '0; m_irq = '0; m_rdata = '0;
  endtask

  task automatic model_step(input logic w, input logic r, input logic [11:0] a,
                            input logic [31:0] d, input logic t);
    logic [1:0]  ex;
    logic [31:0] n_cnt [2];
    logic [31:0] n_rld [2];
    logic        n_arm [2];
    logic        vw;
    logic [11:0] va, ra;
    for (int i = 0; i < 2; i++) begin
      va = (i == 0) ? A_VAL0 : A_VAL1;
      ra = (i == 0) ? A_RLD0 : A_RLD1;
      vw = w && (a == va);
      ex[i] = t && m_ctrl[2*i] && (m_cnt[i] == 0) && (m_ctrl[2*i+1] || m_arm[i]) && !vw;
      n_rld[i] = (w && a == ra) ? d : m_rld[i];
      if (vw) n_cnt[i] = d;
      else if (t && m_ctrl[2*i]) n_cnt[i] = (m_cnt[i] != 0) ? m_cnt[i] - 1 :
                                            (m_ctrl[2*i+1] ? m_rld[i] : 32'd0);
      else n_cnt[i] = m_cnt[i];
      n_arm[i] = vw ? 1'b1 : (ex[i] ? 1'b0 : m_arm[i]);
    end
    if (r) m_rdata = read_model(a);
    m_irq = m_cause & m_mask;
    m_cause = ((w && a == A_CAUSE) ? (m_cause & d[2:1]) : m_cause) | ex;
    if (w && a == A_MASK) m_mask = d[2:1];
    if (w && a == A_CTRL) m_ctrl = d[3:0];
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = n_cnt[i]; m_rld[i] = n_rld[i]; m_arm[i] = n_arm[i];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [11:0] a,
                      input logic [31:0] d, input logic t);
    wr = w; rd = r; addr = a; wdata = d; tick = t;
    model_step(w, r, a, d, t);
    @(posedge clk);
    @(negedge clk);
    chk("R9 irq", {30'd0, irq}, {30'd0, m_irq});
    chk(cur_tag, rdata, m_rdata);
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic rreg(input logic [11:0] a, input string tag);
    cur_tag = tag;
    step(1'b0, 1'b1, a, 32'd0, 1'b0);
  endtask

  task automatic run(input int n, input logic t);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'd0, 32'd0, t);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {30'd0, irq}, 32'd0);

    // R1: reset values
    for (int k = 0; k < 8; k++) rreg(addr_pick(k), "R1");

    // R2: layout and readback, R10: unmapped address
    wreg(A_CTRL, 32'h0000_000A);
    wreg(A_RLD0, 32'h1234_5678);
    wreg(A_RLD1, 32'hCAFE_F00D);
    wreg(A_HOLE, 32'hFFFF_FFFF);
    rreg(A_CTRL, "R2"); rreg(A_RLD0, "R2"); rreg(A_RLD1, "R2");
    rreg(A_HOLE, "R10");
    run(2, 1'b0);
    chk("R10 hold", rdata, 32'd0);

    // R3: decrement only on tick while enabled
    wreg(A_CTRL, 32'h0);
    wreg(A_VAL0, 32'd10);
    wreg(A_CTRL, 32'h1);
    run(5, 1'b1);
    run(3, 1'b0);
    rreg(A_VAL0, "R3");
    chk("R3 direct", rdata, 32'd5);

    // R4: periodic, reload 3
    wreg(A_CTRL, 32'h0);
    wreg(A_CAUSE, 32'h0);
    wreg(A_RLD0, 32'd3);
    wreg(A_VAL0, 32'd0);
    wreg(A_MASK, 32'h2);
    wreg(A_CTRL, 32'h3);
    run(12, 1'b1);
    rreg(A_CAUSE, "R7");
    rreg(A_VAL0, "R4");
    wreg(A_CAUSE, 32'h0);
    run(4, 1'b1);
    rreg(A_CAUSE, "R4");

    // R5: one-shot on timer 1
    wreg(A_CTRL, 32'h0);
    wreg(A_CAUSE, 32'h0);
    wreg(A_MASK, 32'h4);
    wreg(A_VAL1, 32'd3);
    wreg(A_CTRL, 32'h4);
    run(8, 1'b1);
    rreg(A_VAL1, "R5");
    rreg(A_CAUSE, "R5");
    chk("R5 fired", rdata, 32'h4);
    wreg(A_CAUSE, 32'h0);
    run(6, 1'b1);
    rreg(A_CAUSE, "R5");
    chk("R5 no refire", rdata, 32'h0);
    rreg(A_CTRL, "R5");

    // R6: count write collides with a tick at zero
    wreg(A_CTRL, 32'h0);
    wreg(A_CAUSE, 32'h0);
    wreg(A_RLD0, 32'd5);
    wreg(A_VAL0, 32'd0);
    wreg(A_CTRL, 32'h3);
    cur_tag = "R6";
    step(1'b1, 1'b0, A_VAL0, 32'd9, 1'b1);
    rreg(A_VAL0, "R6");
    chk("R6 loaded", rdata, 32'd9);
    rreg(A_CAUSE, "R6");

    // R8: expiry on every tick collides with a clearing write
    wreg(A_RLD0, 32'd0);
    wreg(A_VAL0, 32'd0);
    cur_tag = "R8";
    step(1'b1, 1'b0, A_CAUSE, 32'h0, 1'b1);
    step(1'b1, 1'b0, A_CAUSE, 32'h0, 1'b1);
    rreg(A_CAUSE, "R8");
    chk("R8 kept", rdata, 32'h2);
    wreg(A_CTRL, 32'h0);
    wreg(A_CAUSE, 32'hFFFF_FFFF);
    rreg(A_CAUSE, "R8");
    wreg(A_CAUSE, 32'hFFFF_FFFD);
    rreg(A_CAUSE, "R8");

    // R9: masked periodic timer raises no interrupt
    wreg(A_MASK, 32'h0);
    wreg(A_RLD1, 32'd1);
    wreg(A_CTRL, 32'hC);
    run(10, 1'b1);
    rreg(A_CAUSE, "R9");
    chk("R9 irq quiet", {30'd0, irq}, 32'd0);
    wreg(A_MASK, 32'h4);
    run(3, 1'b0);
    chk("R9 irq on", {30'd0, irq}, 32'h2);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      int unsigned op;
      logic [11:0] a;
      logic [31:0] d;
      logic        t;
      op = $urandom % 4;
      a  = addr_pick($urandom);
      t  = ($urandom % 10) < 7;
      d  = (a == A_VAL0 || a == A_VAL1 || a == A_RLD0 || a == A_RLD1) ?
           ($urandom % 6) : $urandom;
      if (op == 1) step(1'b1, 1'b0, a, d, t);
      else if (op >= 2) begin
        cur_tag = tag_of(a);
        step(1'b0, 1'b1, a, 32'd0, t);
      end else step(1'b0, 1'b0, a, d, t);
    end

    summary();
    $finish;
  end
endmodule